// File: doc/BRIEF.md
# Stretchable Two-Phase Processor Clock Generator

This block derives the two non-overlapping processor clock phases from a faster master clock. The master clock runs at four ticks per processor cycle, so a 3.2 MHz master gives an 800 kHz processor clock. Each cycle has three parts: a one-tick phase-1 pulse, one dead tick, and then phase-2 high until the cycle ends.

When the decoded slow-peripheral select (`io_active_i`) is high at the start of a cycle, that cycle is twice as long, which gives a 400 kHz rate. The extra four ticks all go to phase 2. Phase 2 then stays high for six ticks, which is one and a half normal periods. This gives slow peripheral devices more time to complete a transfer.

A separate divider produces a continuous square wave at half the normal processor rate. Stretching never affects it.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst_ni` is low, `phi1_o`, `phi2_o` and `ref_o` are all low.
- R2: An unstretched cycle lasts TICKS_PER_CYCLE (4) master ticks. `phi1_o` is high for TICKS_PER_CYCLE/4 ticks, both phases are low for TICKS_PER_CYCLE/4 ticks, and `phi2_o` is high for TICKS_PER_CYCLE/2 ticks.
- R3: A stretched cycle lasts 2*TICKS_PER_CYCLE (8) ticks. Its `phi1_o` pulse and dead tick are unchanged, and `phi2_o` is high for 3*TICKS_PER_CYCLE/2 (6) ticks, which is 1.5 normal periods.
- R4: `phi1_o` and `phi2_o` are never high together. `phi2_o` rises only after `phi1_o` has been low for at least one tick.
- R5: `io_active_i` is sampled only on the clock edge at which `phi1_o` rises, and that sample decides the length of the cycle. Changes at other times have no effect on the cycle in progress. A level set during a cycle decides the next cycle.
- R6: The first cycle after reset is unstretched, whatever the level of `io_active_i`.
- R7: `ref_o` is a square wave, high for TICKS_PER_CYCLE ticks and then low for TICKS_PER_CYCLE ticks, with no pause in stretched cycles. It first rises on the TICKS_PER_CYCLE-th edge after reset is released.
- R8: `phi1_o` rises on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, TICKS_PER_CYCLE ticks per normal processor cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_active_i | input | 1 | Slow-peripheral select; high requests a stretched cycle |
| phi1_o | output | 1 | Processor phase-1 clock |
| phi2_o | output | 1 | Processor phase-2 clock |
| ref_o | output | 1 | Free-running square wave at half the normal cycle rate |

## Verification
A bad tick counter shows up within one cycle, at most eight ticks, as a wrong phase-1 width, a missing dead tick or a cycle of the wrong length. A bad stretch flag shows as a phase-2 run of two ticks where six are expected, or the reverse, at the latest when that phase-2 run falls. The reference divider does not share state with the phase sequence, so a fault there shows as a half-period other than four ticks within four ticks of the fault. The bench measures every run length at the ports, and it moves the select input at, before and inside cycle starts.

// File: rtl/twophase_pkg.sv
package twophase_pkg;
  // position of the current tick inside a processor cycle
  typedef enum logic [1:0] {
    SEG_LEAD  = 2'd0,
    SEG_DEAD  = 2'd1,
    SEG_DRIVE = 2'd2,
    SEG_IDLE  = 2'd3
  } seg_e;
endpackage

// File: rtl/twophase_cycle_seq.sv
module twophase_cycle_seq #(
  parameter int unsigned TICKS = 4,
  parameter int unsigned CW    = $clog2(2 * TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_active_i,
  output logic [CW-1:0] tick_o,
  output logic          stretch_o
);
  localparam logic [CW-1:0] LAST_N = CW'(TICKS - 1);
  localparam logic [CW-1:0] LAST_S = CW'(2 * TICKS - 1);

  logic [CW-1:0] tick_q;
  logic          stretch_q;
  logic          first_q;
  logic [CW-1:0] last;

  assign last = stretch_q ? LAST_S : LAST_N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q    <= '0;
      stretch_q <= 1'b0;
      first_q   <= 1'b1;
    end else begin
      // tick 0 is the edge on which phi1 rises: the only sampling point
      if (tick_q == '0) begin
        stretch_q <= io_active_i & ~first_q;
        first_q   <= 1'b0;
      end
      tick_q <= (tick_q == last) ? '0 : tick_q + 1'b1;
    end
  end

  assign tick_o    = tick_q;
  assign stretch_o = stretch_q;
endmodule

// File: rtl/twophase_phase_decode.sv
module twophase_phase_decode
  import twophase_pkg::*;
#(
  parameter int unsigned TICKS = 4,
  parameter int unsigned CW    = $clog2(2 * TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tick_i,
  input  logic          stretch_i,
  output logic          phi1_o,
  output logic          phi2_o
);
  localparam logic [CW-1:0] LEAD_END  = CW'(TICKS / 4);
  localparam logic [CW-1:0] DRIVE_BEG = CW'(TICKS / 2);
  localparam logic [CW-1:0] LAST_N    = CW'(TICKS - 1);
  localparam logic [CW-1:0] LAST_S    = CW'(2 * TICKS - 1);

  seg_e          seg;
  logic [CW-1:0] drive_end;
  logic          phi1_q, phi2_q;

  assign drive_end = stretch_i ? LAST_S : LAST_N;

  always_comb begin
    if (tick_i < LEAD_END)        seg = SEG_LEAD;
    else if (tick_i < DRIVE_BEG)  seg = SEG_DEAD;
    else if (tick_i <= drive_end) seg = SEG_DRIVE;
    else                          seg = SEG_IDLE;
  end

  // registered so the phases change cleanly on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi1_q <= 1'b0;
      phi2_q <= 1'b0;
    end else begin
      phi1_q <= (seg == SEG_LEAD);
      phi2_q <= (seg == SEG_DRIVE);
    end
  end

  assign phi1_o = phi1_q;
  assign phi2_o = phi2_q;
endmodule

// File: rtl/twophase_ref_div.sv
module twophase_ref_div #(
  parameter int unsigned TICKS = 4,
  parameter int unsigned RW    = $clog2(TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_o
);
  localparam logic [RW-1:0] HALF_LAST = RW'(TICKS - 1);

  logic [RW-1:0] cnt_q;
  logic          ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (cnt_q == HALF_LAST) begin
      cnt_q <= '0;
      ref_q <= ~ref_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int unsigned TICKS_PER_CYCLE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_active_i,
  output logic phi1_o,
  output logic phi2_o,
  output logic ref_o
);
  localparam int unsigned CW = $clog2(2 * TICKS_PER_CYCLE);
  localparam int unsigned RW = $clog2(TICKS_PER_CYCLE);

  if (TICKS_PER_CYCLE < 4 || (TICKS_PER_CYCLE % 4) != 0) begin : g_bad_ticks
    $error("TICKS_PER_CYCLE must be a multiple of 4");
  end

  logic [CW-1:0] tick;
  logic          stretch;

  twophase_cycle_seq #(.TICKS(TICKS_PER_CYCLE), .CW(CW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_active_i (io_active_i),
    .tick_o      (tick),
    .stretch_o   (stretch)
  );

  twophase_phase_decode #(.TICKS(TICKS_PER_CYCLE), .CW(CW)) i_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .stretch_i (stretch),
    .phi1_o    (phi1_o),
    .phi2_o    (phi2_o)
  );

  twophase_ref_div #(.TICKS(TICKS_PER_CYCLE), .RW(RW)) i_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_o  (ref_o)
  );
endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk #(
  parameter int unsigned TICKS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic phi1_i,
  input logic phi2_i,
  input logic ref_i
);
  logic [15:0] p1_run, p2_run, ref_since;
  logic        ref_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_run    <= '0;
      p2_run    <= '0;
      ref_since <= '1;
      ref_prev  <= 1'b0;
    end else begin
      p1_run    <= phi1_i ? p1_run + 16'd1 : 16'd0;
      p2_run    <= phi2_i ? p2_run + 16'd1 : 16'd0;
      ref_prev  <= ref_i;
      ref_since <= (ref_i != ref_prev) ? 16'd0 : ref_since + 16'd1;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi1_i && phi2_i)); // R4

  AST_DEAD_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phi2_i) |-> !$past(phi1_i)); // R4

  AST_PHI1_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi1_i) |-> (p1_run == 16'(TICKS / 4))); // R2

  AST_PHI2_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi2_i) |-> (p2_run == 16'(TICKS / 2) || p2_run == 16'(3 * TICKS / 2))); // R3

  AST_REF_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i != ref_prev) |-> (ref_since == 16'(TICKS - 1))); // R7

  AST_REF_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_since < 16'(TICKS) || ref_since == 16'hFFFF)); // R7
endmodule

bind twophase_clkgen twophase_clkgen_chk #(.TICKS(TICKS_PER_CYCLE)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .phi1_i (phi1_o),
  .phi2_i (phi2_o),
  .ref_i  (ref_o)
);

// File: tb/test_twophase_clkgen.sv
`timescale 1ns/1ps
module test_twophase_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_active = 1'b0;
  logic phi1, phi2, ref_w;
  int   checks = 0;
  int   errors = 0;
  int   overlaps = 0;

  always #2 clk = ~clk;

  twophase_clkgen #(.TICKS_PER_CYCLE(4)) i_twophase_clkgen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .io_active_i (io_active),
    .phi1_o      (phi1),
    .phi2_o      (phi2),
    .ref_o       (ref_w)
  );

  always @(negedge clk) if (rst_n && phi1 && phi2) overlaps++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // leaves the bench at the negedge just after the first phi1 rise
  task automatic do_reset(input logic io);
    @(negedge clk);
    rst_n = 1'b0;
    io_active = io;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(output int p1, output int gap, output int p2, output int tot);
    int tail;
    p1 = 0; gap = 0; p2 = 0; tail = 0;
    while (phi1 && p1 < 64) begin p1++; @(negedge clk); end
    while (!phi1 && !phi2 && gap < 64) begin gap++; @(negedge clk); end
    while (phi2 && p2 < 64) begin p2++; @(negedge clk); end
    while (!phi1 && tail < 64) begin tail++; @(negedge clk); end
    tot = p1 + gap + p2 + tail;
  endtask

  task automatic check_cycle(input string req, input int exp_p2, input int exp_tot);
    int p1, gap, p2, tot;
    measure(p1, gap, p2, tot);
    chk(p1 == 1, req, "phi1 width", p1, 1);
    chk(gap == 1, "R4", "dead ticks", gap, 1);
    chk(p2 == exp_p2, req, "phi2 width", p2, exp_p2);
    chk(tot == exp_tot, req, "cycle length", tot, exp_tot);
  endtask

  task automatic t_reset;
    int k;
    @(negedge clk);
    rst_n = 1'b0;
    io_active = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!phi1 && !phi2 && !ref_w, "R1", "outputs in reset",
          {29'd0, phi1, phi2, ref_w}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(phi1 == 1'b1, "R8", "phi1 after first edge", int'(phi1), 1);
    k = 1;
    while (!ref_w && k < 64) begin k++; @(negedge clk); end
    chk(k == 4, "R7", "first ref rise edge", k, 4);
  endtask

  task automatic t_first_cycle;
    do_reset(1'b1);
    check_cycle("R6", 2, 4);
    check_cycle("R3", 6, 8);
  endtask

  task automatic t_normal;
    do_reset(1'b0);
    repeat (3) check_cycle("R2", 2, 4);
  endtask

  task automatic t_stretch;
    do_reset(1'b1);
    check_cycle("R6", 2, 4);
    repeat (3) check_cycle("R3", 6, 8);
  endtask

  task automatic t_sampling;
    do_reset(1'b0);
    io_active = 1'b1;              // after phi1 rose: this cycle stays short
    check_cycle("R5", 2, 4);
    io_active = 1'b0;              // stretched cycle already started
    check_cycle("R5", 6, 8);
    check_cycle("R5", 2, 4);
    fork
      check_cycle("R5", 2, 4);
      begin
        @(negedge clk); io_active = 1'b1;
        @(negedge clk); io_active = 1'b0;
      end
    join
    check_cycle("R5", 2, 4);
  endtask

  task automatic t_ref;
    int h, l;
    do_reset(1'b1);
    while (ref_w) @(negedge clk);
    while (!ref_w) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      io_active = (i % 2 == 0);
      h = 0; l = 0;
      while (ref_w && h < 64) begin h++; @(negedge clk); end
      while (!ref_w && l < 64) begin l++; @(negedge clk); end
      chk(h == 4, "R7", "ref high ticks", h, 4);
      chk(l == 4, "R7", "ref low ticks", l, 4);
    end
    io_active = 1'b0;
  endtask

  initial begin
    t_reset();
    t_first_cycle();
    t_normal();
    t_stretch();
    t_sampling();
    t_ref();
    chk(overlaps == 0, "R4", "phase overlap ticks", overlaps, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule